// File: doc/BRIEF.md
# Chained Configuration Serial Loader

This block fills a bank of nine 8-bit configuration registers from a two-wire serial stream. It uses no bus protocol. The registers are linked end to end into one 68-bit shift chain. On each falling edge of a serial clock, the chain moves one place and takes a new bit from the serial data line. The two upper bits of the first two registers are not part of the chain, so 68 bits fill all nine registers. The last bit of the chain drives a readback pin at all times. Old contents therefore stream out on that pin while new contents stream in.

Loading is allowed only while two strap inputs are both high. The strap inputs are a mode strap and a power-down pin. The registers under the chain hold the values being loaded. The values that the rest of the chip sees appear on a separate configuration output. That output takes a copy of the whole register bank when the mode strap is pulled low. All four serial and strap inputs are asynchronous to the system clock. Each passes through a two-stage synchronizer. Edges are then found on the synchronized copies.

There is no handshake at the serial interface. A bit is accepted on every qualified falling edge, and the block never holds off the sender.

Top module: `chained_cfg_loader`

## Requirements
- R1: The chain shifts only when the synchronized mode strap and the synchronized power-down pin are both high. Otherwise every chain bit keeps its value and `tail_o` does not change.
- R2: Each input is synchronized through two flip-flops. A falling edge of `sclk_i` first seen low at rising clock edge e shifts the chain at edge e+2. The bit shifted in is the `sdata_i` level sampled at edge e. It enters register 0 bit 0.
- R3: Bit 0 of each register takes bit 7 of the register before it. The exceptions are registers 0 and 1, where bit 5 feeds the next register's bit 0. So register 0 bit 5 feeds register 1 bit 0, and register 1 bit 5 feeds register 2 bit 0.
- R4: `tail_o` always equals register 8 bit 7. A bit shifted into register 0 bit 0 reaches `tail_o` after 68 shifts.
- R5: Bits 7:6 of registers 0 and 1 never change while shifting.
- R6: `shift_count_o` clears to 0 in every cycle where the enable of R1 is false. Otherwise it counts shifts and saturates at 68. Reset clears it.
- R7: `cfg_o` bit 8*r+b is register r bit b. Reset clears `cfg_o`. `cfg_o` loads the whole register bank on the cycle the synchronized mode strap is seen falling, and holds its value at all other times.
- R8: The chain registers have no reset. A reset clears `cfg_o` and the counter but leaves the loaded chain intact, and a later strap fall copies it out again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset for the synchronizers, counter and output copy |
| strap_i | input | 1 | Mode strap; high selects serial loading, a fall applies the loaded bank |
| pdn_i | input | 1 | Power-down pin; must be high for loading |
| sclk_i | input | 1 | Serial shift clock; the chain moves on its falling edge |
| sdata_i | input | 1 | Serial data bit |
| tail_o | output | 1 | Last chain bit (register 8 bit 7), the readback stream |
| shift_count_o | output | 7 | Shifts since loading was enabled, saturating at 68 |
| cfg_o | output | 72 | Applied register bank, register r bit b at index 8*r+b |

## Verification
The assertions are checked on every cycle. They cover these points:
- every link of the chain, including the two places where the chain skips bits and the tail;
- the hold of the chain when no shift occurs;
- the fixed upper bits of registers 0 and 1;
- the counter's clear, step and saturation;
- the rule that `cfg_o` copies the bank only on a strap fall.

The bench's scenarios show behaviour that spans many cycles: the 68-shift latency from input to `tail_o`, streaming of old contents during a reload, and a reset that leaves the chain intact so the values can be applied again.

// File: rtl/ccl_pkg.sv
package ccl_pkg;

  function automatic int link_len(int nreg, int rw, int nshort, int drop);
    return nreg * rw - nshort * drop;
  endfunction

  // chain position of a flat register bit, -1 when the bit is outside the chain
  function automatic int flat_to_link(int idx, int rw, int nshort, int drop);
    int r;
    int b;
    r = idx / rw;
    b = idx % rw;
    if (r < nshort) begin
      if (b >= rw - drop) return -1;
      return r * (rw - drop) + b;
    end
    return nshort * (rw - drop) + (r - nshort) * rw + b;
  endfunction

  // flat register bit holding a given chain position
  function automatic int link_to_flat(int k, int rw, int nshort, int drop);
    int sw;
    sw = rw - drop;
    if (k < nshort * sw) return (k / sw) * rw + (k % sw);
    return nshort * rw + (k - nshort * sw);
  endfunction

endpackage

// File: rtl/ccl_sync.sv
module ccl_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      sync_o   <= '0;
    end else begin
      stage1_q <= in_i;
      sync_o   <= stage1_q;
    end
  end
endmodule

// File: rtl/ccl_chain.sv
module ccl_chain
  import ccl_pkg::*;
#(
  parameter int NUM_REGS   = 9,
  parameter int REG_W      = 8,
  parameter int NUM_SHORT  = 2,
  parameter int SHORT_DROP = 2
) (
  input  logic                        clk,
  input  logic                        shift_i,
  input  logic                        data_i,
  output logic [NUM_REGS*REG_W-1:0]   regs_o
);
  localparam int TOTAL = NUM_REGS * REG_W;

  for (genvar i = 0; i < TOTAL; i++) begin : g_bit
    localparam int K = flat_to_link(i, REG_W, NUM_SHORT, SHORT_DROP);
    logic cell_q;
    if (K < 0) begin : g_fixed
      // outside the chain: no reset, never written
      always_ff @(posedge clk) cell_q <= cell_q;
    end else if (K == 0) begin : g_head
      always_ff @(posedge clk) if (shift_i) cell_q <= data_i;
    end else begin : g_link
      localparam int SRC = link_to_flat(K - 1, REG_W, NUM_SHORT, SHORT_DROP);
      always_ff @(posedge clk) if (shift_i) cell_q <= regs_o[SRC];
    end
    assign regs_o[i] = cell_q;
  end
endmodule

// File: rtl/ccl_count.sv
module ccl_count #(
  parameter int LIMIT = 68,
  parameter int W     = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         step_i,
  output logic [W-1:0] count_o
);
  localparam logic [W-1:0] TOP = W'(LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       count_o <= '0;
    else if (!en_i)                   count_o <= '0;
    else if (step_i && count_o < TOP) count_o <= count_o + 1'b1;
  end
endmodule

// File: rtl/chained_cfg_loader.sv
module chained_cfg_loader
  import ccl_pkg::*;
#(
  parameter int NUM_REGS   = 9,
  parameter int REG_W      = 8,
  parameter int NUM_SHORT  = 2,
  parameter int SHORT_DROP = 2,
  parameter int CHAIN_LEN  = link_len(NUM_REGS, REG_W, NUM_SHORT, SHORT_DROP),
  parameter int CNT_W      = $clog2(CHAIN_LEN + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       strap_i,
  input  logic                       pdn_i,
  input  logic                       sclk_i,
  input  logic                       sdata_i,
  output logic                       tail_o,
  output logic [CNT_W-1:0]           shift_count_o,
  output logic [NUM_REGS*REG_W-1:0]  cfg_o
);
  localparam int TOTAL     = NUM_REGS * REG_W;
  localparam int TAIL_FLAT = link_to_flat(CHAIN_LEN - 1, REG_W, NUM_SHORT, SHORT_DROP);

  logic [3:0]       sync_s;
  logic             strap_s, pdn_s, sclk_s, data_s;
  logic             strap_p, sclk_p;
  logic             load_en, shift_now, cap_now;
  logic [TOTAL-1:0] chain_q;

  ccl_sync #(.W(4)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_i   ({strap_i, pdn_i, sclk_i, sdata_i}),
    .sync_o (sync_s)
  );
  assign {strap_s, pdn_s, sclk_s, data_s} = sync_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_p <= 1'b0;
      sclk_p  <= 1'b0;
    end else begin
      strap_p <= strap_s;
      sclk_p  <= sclk_s;
    end
  end

  assign load_en   = strap_s & pdn_s;
  assign shift_now = load_en & sclk_p & ~sclk_s;
  assign cap_now   = strap_p & ~strap_s;

  ccl_chain #(
    .NUM_REGS   (NUM_REGS),
    .REG_W      (REG_W),
    .NUM_SHORT  (NUM_SHORT),
    .SHORT_DROP (SHORT_DROP)
  ) u_chain (
    .clk     (clk),
    .shift_i (shift_now),
    .data_i  (data_s),
    .regs_o  (chain_q)
  );

  ccl_count #(.LIMIT(CHAIN_LEN), .W(CNT_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (load_en),
    .step_i  (shift_now),
    .count_o (shift_count_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cfg_o <= '0;
    else if (cap_now) cfg_o <= chain_q;
  end

  assign tail_o = chain_q[TAIL_FLAT];
endmodule

// File: rtl/ccl_checker.sv
module ccl_checker
  import ccl_pkg::*;
#(
  parameter int NUM_REGS   = 9,
  parameter int REG_W      = 8,
  parameter int NUM_SHORT  = 2,
  parameter int SHORT_DROP = 2,
  parameter int CHAIN_LEN  = 68,
  parameter int CNT_W      = 7
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      en_i,
  input logic                      shift_i,
  input logic                      sdata_i,
  input logic                      cap_i,
  input logic [NUM_REGS*REG_W-1:0] chain_i,
  input logic                      tail_i,
  input logic [CNT_W-1:0]          count_i,
  input logic [NUM_REGS*REG_W-1:0] cfg_i
);
  localparam int TOTAL = NUM_REGS * REG_W;
  localparam int PRE_TAIL = link_to_flat(CHAIN_LEN - 2, REG_W, NUM_SHORT, SHORT_DROP);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(CHAIN_LEN);

  function automatic logic [TOTAL-1:0] fixed_mask();
    logic [TOTAL-1:0] m;
    m = '0;
    for (int i = 0; i < TOTAL; i++)
      if (flat_to_link(i, REG_W, NUM_SHORT, SHORT_DROP) < 0) m[i] = 1'b1;
    return m;
  endfunction
  localparam logic [TOTAL-1:0] FIXED = fixed_mask();

  p_head_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_i |=> chain_i[0] == $past(sdata_i));

  for (genvar k = 1; k < CHAIN_LEN; k++) begin : g_link_chk
    localparam int DST = link_to_flat(k, REG_W, NUM_SHORT, SHORT_DROP);
    localparam int SRC = link_to_flat(k - 1, REG_W, NUM_SHORT, SHORT_DROP);
    p_link_r3: assert property (@(posedge clk) disable iff (!rst_n)
      shift_i |=> chain_i[DST] == $past(chain_i[SRC]));
  end

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(chain_i));

  p_tail_r4: assert property (@(posedge clk) disable iff (!rst_n)
    shift_i |=> tail_i == $past(chain_i[PRE_TAIL]));

  p_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(chain_i & FIXED));

  p_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    count_i <= TOP);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> count_i == '0);

  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && shift_i && count_i < TOP) |=> count_i == $past(count_i) + 1'b1);

  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_i |=> $stable(cfg_i));

  p_cfg_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> cfg_i == $past(chain_i));
endmodule

bind chained_cfg_loader ccl_checker #(
  .NUM_REGS   (NUM_REGS),
  .REG_W      (REG_W),
  .NUM_SHORT  (NUM_SHORT),
  .SHORT_DROP (SHORT_DROP),
  .CHAIN_LEN  (CHAIN_LEN),
  .CNT_W      (CNT_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en_i    (load_en),
  .shift_i (shift_now),
  .sdata_i (data_s),
  .cap_i   (cap_now),
  .chain_i (chain_q),
  .tail_i  (tail_o),
  .count_i (shift_count_o),
  .cfg_i   (cfg_o)
);

// File: tb/chained_cfg_loader_tb.sv
module chained_cfg_loader_tb;
  localparam int LEN = 68;
  localparam int TOT = 72;

  logic clk = 1'b0;
  logic rst_n = 1'b0, strap = 1'b0, pdn = 1'b0, sclk = 1'b0, sdata = 1'b0;
  wire            tail;
  wire [6:0]      cnt;
  wire [TOT-1:0]  cfg;

  always #5 clk = ~clk;

  chained_cfg_loader u_dut (
    .clk(clk), .rst_n(rst_n), .strap_i(strap), .pdn_i(pdn),
    .sclk_i(sclk), .sdata_i(sdata), .tail_o(tail),
    .shift_count_o(cnt), .cfg_o(cfg)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;
  bit sent[$];

  // chain position k -> flat cfg index (R3, R7 layout)
  function automatic int pos2flat(int k);
    if (k < 6)  return k;
    if (k < 12) return 8 + (k - 6);
    return 16 + (k - 12);
  endfunction

  localparam logic [TOT-1:0] FIXED_BITS = 72'hC0C0;

  task automatic chk(string tag, logic [TOT-1:0] act, logic [TOT-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [LEN-1:0] m_chain = '0;
  logic [LEN-1:0] m_cap = '0;
  int  m_shifts = 0;
  int  m_cnt = 0;
  bit  cap_known = 1'b0;
  logic st1 = 0, st2 = 0, st3 = 0, pd1 = 0, pd2 = 0;
  logic sc1 = 0, sc2 = 0, sc3 = 0, sd1 = 0, sd2 = 0;
  logic m_en, m_fall, m_sh, m_cp;

  always @(posedge clk) begin
    if (!rst_n) begin
      st1 = 0; st2 = 0; st3 = 0; pd1 = 0; pd2 = 0;
      sc1 = 0; sc2 = 0; sc3 = 0; sd1 = 0; sd2 = 0;
      m_cnt = 0;
      cap_known = 1'b0;
    end else begin
      m_en   = st2 & pd2;
      m_fall = sc3 & ~sc2;
      m_sh   = m_en & m_fall;
      m_cp   = st3 & ~st2;
      if (m_cp) begin
        m_cap = m_chain;
        cap_known = (m_shifts >= LEN);
      end
      if (!m_en) m_cnt = 0;
      else if (m_sh && m_cnt < LEN) m_cnt++;
      if (m_sh) begin
        m_chain = {m_chain[LEN-2:0], sd2};
        m_shifts++;
      end
      st3 = st2; st2 = st1; st1 = strap;
      pd2 = pd1; pd1 = pdn;
      sc3 = sc2; sc2 = sc1; sc1 = sclk;
      sd2 = sd1; sd1 = sdata;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 R6 shift_count per cycle", TOT'(cnt), TOT'(m_cnt));
      if (m_shifts >= LEN) chk("R3 R4 tail per cycle", TOT'(tail), TOT'(m_chain[LEN-1]));
      if (cap_known) begin
        logic [TOT-1:0] e;
        logic [TOT-1:0] a;
        e = '0;
        a = '0;
        for (int k = 0; k < LEN; k++) begin
          e[pos2flat(k)] = m_cap[k];
          a[pos2flat(k)] = cfg[pos2flat(k)];
        end
        chk("R3 R7 cfg per cycle", a, e);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(bit b);
    sdata = b;
    sclk = 1'b1;
    settle(3);
    sclk = 1'b0;
    settle(3);
    if (strap && pdn) sent.push_back(b);
  endtask

  function automatic bit pat(int i);
    return ((i * 7) % 5) < 2;
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic tail_before;
    logic [TOT-1:0] fixed_ref;
    int n;
    settle(3);
    rst_n = 1'b1;
    settle(1);
    chk("R7 cfg after reset", cfg, '0);
    chk("R6 count after reset", TOT'(cnt), '0);

    // full load
    strap = 1'b1; pdn = 1'b1;
    settle(4);
    for (int i = 0; i < LEN; i++) send(pat(i));
    settle(4);
    chk("R6 count reaches 68", TOT'(cnt), TOT'(LEN));
    chk("R4 first bit at tail after 68 shifts", TOT'(tail), TOT'(pat(0)));

    // reload: old contents stream out, counter saturates
    for (int i = 0; i < 12; i++) send(~pat(i + 3));
    settle(4);
    chk("R6 count saturates", TOT'(cnt), TOT'(LEN));
    chk("R4 tail streams old contents", TOT'(tail), TOT'(pat(12)));

    // apply
    strap = 1'b0;
    settle(5);
    n = sent.size();
    chk("R7 cfg reg0 bit0 newest", TOT'(cfg[0]), TOT'(sent[n-1]));
    chk("R3 cfg reg1 bit0 from reg0 bit5", TOT'(cfg[8]), TOT'(sent[n-7]));
    chk("R3 cfg reg2 bit0 from reg1 bit5", TOT'(cfg[16]), TOT'(sent[n-13]));
    chk("R4 cfg reg8 bit7 oldest", TOT'(cfg[71]), TOT'(sent[n-68]));
    chk("R6 count cleared by strap low", TOT'(cnt), '0);
    fixed_ref = cfg & FIXED_BITS;

    // R1: disabled loading, strap low
    tail_before = tail;
    for (int i = 0; i < 5; i++) send(~tail_before);
    settle(4);
    chk("R1 no shift with strap low: count", TOT'(cnt), '0);
    chk("R1 no shift with strap low: tail", TOT'(tail), TOT'(tail_before));

    // R1: disabled loading, power-down pin low
    strap = 1'b1; pdn = 1'b0;
    settle(4);
    for (int i = 0; i < 5; i++) send(~tail_before);
    settle(4);
    chk("R1 no shift with pdn low: count", TOT'(cnt), '0);
    chk("R1 no shift with pdn low: tail", TOT'(tail), TOT'(tail_before));

    // partial load, then enable drop
    pdn = 1'b1;
    settle(4);
    for (int i = 0; i < 10; i++) send(pat(i + 40));
    settle(4);
    chk("R6 count after 10 shifts", TOT'(cnt), TOT'(10));
    pdn = 1'b0;
    settle(4);
    chk("R6 count clears when pdn drops", TOT'(cnt), '0);
    pdn = 1'b1;

    // R8: reset keeps chain
    rst_n = 1'b0;
    settle(2);
    chk("R7 cfg cleared by reset", cfg, '0);
    rst_n = 1'b1;
    settle(5);
    strap = 1'b0;
    settle(5);
    n = sent.size();
    chk("R8 chain kept across reset: reg0 bit0", TOT'(cfg[0]), TOT'(sent[n-1]));
    chk("R8 chain kept across reset: reg1 bit3", TOT'(cfg[11]), TOT'(sent[n-10]));
    chk("R5 fixed bits unchanged", cfg & FIXED_BITS, fixed_ref);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule